// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Lookup and Replacement Core

This block holds the tags, valid flags and data blocks of a small two-way set-associative cache, and it decides hit or miss. A lookup address is split into a tag, a set number and a byte offset. The set number picks one set. Both ways of that set compare their stored tags against the lookup tag in the same cycle, and the matching way steers the data multiplexer. The result is combinational, so it is available in the same cycle as the address.

Each set keeps one recency bit. The bit names the way that was not touched most recently. The block presents a victim way for the looked-up set, and it uses the same rule to place a refill. That rule takes an empty way first, way 0 before way 1. If neither way is empty, the rule takes the way named by the recency bit. A refill arrives on a separate fill port as an address and a data block, and it is written at the next clock edge. Write policy and the protocol of the memory behind the cache are handled elsewhere.

Top module: `sa2_lookup`

## Requirements
- R1: After reset every entry is invalid and every recency bit is 0, so any lookup misses and reports victim way 0.
- R2: The block number is the address shifted right by OFFSET_W bits. The set is the block number modulo SETS, which is address bits [OFFSET_W+INDEX_W-1:OFFSET_W]. The tag is the bits above the set field. With the defaults, address 0x0030 is block 12, set 0, tag 0x003. An entry stored at one set never matches a lookup in another set, even when the tags are equal.
- R3: `lk_hit` is 1 exactly when one way of the addressed set is valid and holds the lookup tag. Bit w of `lk_way_hit` marks a hit in way w.
- R4: On a hit, `lk_data` equals the data block of the hitting way. On a miss, `lk_data` is all zeros.
- R5: At most one bit of `lk_way_hit` is set at any time.
- R6: The victim way is chosen in this order: way 0 if it is invalid, else way 1 if it is invalid, else the way named by the set's recency bit. A fill writes the fill address's tag and data into that victim way of its set. The written entry is valid from the next cycle.
- R7: A lookup that hits while `lk_valid` is 1 sets the set's recency bit to the other way at the clock edge.
- R8: A fill sets the recency bit of its set to the way it did not write.
- R9: When a fill and a valid hit update the same set in one cycle, the fill's recency update takes effect.
- R10: A lookup with `lk_valid` at 0 still reports hit, data and victim, but it leaves the recency bits unchanged.
- R11: The low OFFSET_W address bits have no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup counts as an access for recency |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_hit | output | 1 | One way of the set matched |
| lk_way_hit | output | 2 | Per-way match flags |
| lk_data | output | DATA_W | Data block of the hitting way, zero on miss |
| lk_victim | output | 1 | Way a refill of the looked-up set would replace |
| fill_en | input | 1 | Write a refill this cycle |
| fill_addr | input | ADDR_W | Byte address of the refilled block |
| fill_data | input | DATA_W | Refilled data block |

## Verification
On every cycle, the assertions check four things: that no two ways match together, that a miss drives zero data, and that an empty way is offered as victim before a full one. They also check that each recency update or fill lands in the state the next cycle. Only the bench's sequences can show that the recency bit picks the right way over several evictions. The same holds for set placement by block-number modulo, for the fill winning a same-set clash, and for a non-counted lookup leaving the replacement order alone.

// File: rtl/sa2_pkg.sv
package sa2_pkg;

  localparam int unsigned NUM_WAYS = 2;

  // Replacement choice: empty way 0, then empty way 1, then the recency bit.
  function automatic logic pick_victim(input logic valid0, input logic valid1,
                                       input logic lru_bit);
    if (!valid0) return 1'b0;
    if (!valid1) return 1'b1;
    return lru_bit;
  endfunction

  // The way not just used.
  function automatic logic other_way(input logic way);
    return ~way;
  endfunction

endpackage

// File: rtl/sa2_way_store.sv
module sa2_way_store #(
  parameter int unsigned SETS   = 4,
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [SETS-1:0]   valid_all
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid  = valid_q[rd_set];
  assign rd_tag    = tag_q[rd_set];
  assign rd_data   = data_q[rd_set];
  assign valid_all = valid_q;

  // R6: a written entry is valid with its tag on the next cycle
  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_set)] && tag_q[$past(wr_set)] == $past(wr_tag)));

endmodule

// File: rtl/sa2_hit_sel.sv
module sa2_hit_sel #(
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             way_valid,
  input  logic [1:0][TAG_W-1:0]  way_tag,
  input  logic [1:0][DATA_W-1:0] way_data,
  input  logic [TAG_W-1:0]       look_tag,
  output logic [1:0]             way_hit,
  output logic                   hit,
  output logic [DATA_W-1:0]      data
);

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = way_valid[w] && (way_tag[w] == look_tag);
  end

  assign hit = |way_hit;

  always_comb begin
    data = '0;
    for (int w = 0; w < 2; w++) data = data | ({DATA_W{way_hit[w]}} & way_data[w]);
  end

  // R5: the two ways never match together
  p_single_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

endmodule

// File: rtl/sa2_lru.sv
module sa2_lru #(
  parameter int unsigned SETS = 4,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic             fill_way,
  output logic [SETS-1:0]  lru_q
);
  import sa2_pkg::*;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) lru_q[s] <= 1'b0;
      else if (fill_en && fill_set == IDX_W'(s)) lru_q[s] <= other_way(fill_way);
      else if (hit_en && hit_set == IDX_W'(s)) lru_q[s] <= other_way(hit_way);
    end
  end

  // R8: fill points the recency bit away from the written way
  p_fill_lru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (lru_q[$past(fill_set)] == !$past(fill_way)));

  // R7: a counted hit points the recency bit away from the hit way
  p_hit_lru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !(fill_en && fill_set == hit_set)) |=>
      (lru_q[$past(hit_set)] == !$past(hit_way)));

  // R10: no counted access, no recency change
  p_idle_lru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_en && !fill_en) |=> $stable(lru_q));

endmodule

// File: rtl/sa2_lookup.sv
module sa2_lookup #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned OFFSET_W = 2,
  parameter int unsigned SETS     = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [1:0]        lk_way_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_victim,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  import sa2_pkg::*;

  localparam int unsigned INDEX_W = $clog2(SETS);
  localparam int unsigned TAG_W   = ADDR_W - OFFSET_W - INDEX_W;

  // Set = block number modulo SETS; tag = block number divided by SETS.
  function automatic logic [INDEX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFFSET_W +: INDEX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [INDEX_W-1:0]     lk_set, fl_set;
  logic [TAG_W-1:0]       lk_tag, fl_tag;
  logic [1:0]             rd_valid;
  logic [1:0][TAG_W-1:0]  rd_tag;
  logic [1:0][DATA_W-1:0] rd_data;
  logic [1:0][SETS-1:0]   valid_all;
  logic [SETS-1:0]        lru_q;
  logic                   fl_way;
  logic [1:0]             way_wr;
  logic                   hit_update;
  logic                   unused_offset;

  assign lk_set = set_of(lk_addr);
  assign lk_tag = tag_of(lk_addr);
  assign fl_set = set_of(fill_addr);
  assign fl_tag = tag_of(fill_addr);
  assign unused_offset = ^{lk_addr[OFFSET_W-1:0], fill_addr[OFFSET_W-1:0]};

  assign fl_way = pick_victim(valid_all[0][fl_set], valid_all[1][fl_set], lru_q[fl_set]);

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_wr[w] = fill_en && (fl_way == 1'(w));
    sa2_way_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (way_wr[w]),
      .wr_set   (fl_set),
      .wr_tag   (fl_tag),
      .wr_data  (fill_data),
      .rd_set   (lk_set),
      .rd_valid (rd_valid[w]),
      .rd_tag   (rd_tag[w]),
      .rd_data  (rd_data[w]),
      .valid_all(valid_all[w])
    );
  end

  sa2_hit_sel #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_hit (
    .clk      (clk),
    .rst_n    (rst_n),
    .way_valid(rd_valid),
    .way_tag  (rd_tag),
    .way_data (rd_data),
    .look_tag (lk_tag),
    .way_hit  (lk_way_hit),
    .hit      (lk_hit),
    .data     (lk_data)
  );

  assign hit_update = lk_valid && lk_hit;

  sa2_lru #(.SETS(SETS)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_en  (hit_update),
    .hit_set (lk_set),
    .hit_way (lk_way_hit[1]),
    .fill_en (fill_en),
    .fill_set(fl_set),
    .fill_way(fl_way),
    .lru_q   (lru_q)
  );

  assign lk_victim = pick_victim(rd_valid[0], rd_valid[1], lru_q[lk_set]);

  // R6: an empty way is always offered before a full one
  p_victim_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid[0] || !rd_valid[1]) |-> !rd_valid[lk_victim]);

  // R4: a miss drives zero data
  p_miss_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_data == '0));

endmodule

// File: tb/sa2_lookup_tb.sv
module sa2_lookup_tb;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  // kind: 0 counted lookup, 1 fill, 2 uncounted lookup
  typedef struct packed {
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              exp_hit;
    logic [DATA_W-1:0] exp_data;
    logic              exp_vic;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0050, 32'h0,        1'b0, 32'h0,        1'b0}, // R1 empty
    '{2'd1, 16'h0050, 32'hAAAA0001, 1'b0, 32'h0,        1'b0}, // fill A way0
    '{2'd0, 16'h0050, 32'h0,        1'b1, 32'hAAAA0001, 1'b1}, // R3 R6 empty way1
    '{2'd1, 16'h0030, 32'hBBBB0002, 1'b0, 32'h0,        1'b0}, // fill B way1
    '{2'd0, 16'h0030, 32'h0,        1'b1, 32'hBBBB0002, 1'b0}, // R8 R4
    '{2'd0, 16'h0053, 32'h0,        1'b1, 32'hAAAA0001, 1'b0}, // R11 offset
    '{2'd0, 16'h0090, 32'h0,        1'b0, 32'h0,        1'b1}, // R7 after A hit
    '{2'd1, 16'h0090, 32'hCCCC0003, 1'b0, 32'h0,        1'b0}, // fill C evicts B
    '{2'd0, 16'h0030, 32'h0,        1'b0, 32'h0,        1'b0}, // R6 B gone
    '{2'd0, 16'h0090, 32'h0,        1'b1, 32'hCCCC0003, 1'b0}, // R3 C
    '{2'd2, 16'h0050, 32'h0,        1'b1, 32'hAAAA0001, 1'b0}, // R10 no count
    '{2'd0, 16'h0090, 32'h0,        1'b1, 32'hCCCC0003, 1'b0}, // R10 unchanged
    '{2'd0, 16'h0030, 32'h0,        1'b0, 32'h0,        1'b0}, // R2 block 12 set0
    '{2'd1, 16'h0038, 32'hDDDD0004, 1'b0, 32'h0,        1'b0}, // fill set2
    '{2'd0, 16'h0038, 32'h0,        1'b1, 32'hDDDD0004, 1'b1}, // R2 set2 hit
    '{2'd0, 16'h00A8, 32'h0,        1'b0, 32'h0,        1'b1}  // R2 other tag
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              lk_hit;
  logic [1:0]        lk_way_hit;
  logic [DATA_W-1:0] lk_data;
  logic              lk_victim;
  logic              fill_en = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [DATA_W-1:0] fill_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sa2_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_way_hit(lk_way_hit), .lk_data(lk_data),
    .lk_victim(lk_victim), .fill_en(fill_en), .fill_addr(fill_addr),
    .fill_data(fill_data)
  );

  task automatic check(input string req, input logic eh, input logic [DATA_W-1:0] ed,
                       input logic ev);
    n_cmp++;
    if (lk_hit !== eh || lk_data !== ed || lk_victim !== ev ||
        $countones(lk_way_hit) !== int'(eh)) begin
      n_bad++;
      $display("FAIL %s addr=%h: hit=%b way_hit=%b data=%h victim=%b expected hit=%b data=%h victim=%b",
               req, lk_addr, lk_hit, lk_way_hit, lk_data, lk_victim, eh, ed, ev);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lk_valid = 1'b0;
      fill_en  = 1'b0;
      if (VEC[i].kind == 2'd1) begin
        fill_en   = 1'b1;
        fill_addr = VEC[i].addr;
        fill_data = VEC[i].wdata;
      end else begin
        lk_addr  = VEC[i].addr;
        lk_valid = (VEC[i].kind == 2'd0);
        #2;
        check($sformatf("R1-table row %0d", i), VEC[i].exp_hit, VEC[i].exp_data, VEC[i].exp_vic);
      end
    end
    // R9: same-set clash; C hit wants recency 0, fill into way0 wants 1
    @(negedge clk);
    lk_addr = 16'h0090; lk_valid = 1'b1;
    fill_en = 1'b1; fill_addr = 16'h0070; fill_data = 32'hEEEE0005;
    #2;
    check("R3 hit during fill", 1'b1, 32'hCCCC0003, 1'b0);
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0; lk_addr = 16'h0070;
    #2;
    check("R9 fill wins recency", 1'b1, 32'hEEEE0005, 1'b1);
    @(negedge clk);
    lk_addr = 16'h0050;
    #2;
    check("R6 lru victim evicted", 1'b0, 32'h0, 1'b1);
    // R1: reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lk_addr = 16'h0090;
    #2;
    check("R1 after reset", 1'b0, 32'h0, 1'b0);
    lk_addr = 16'h0038;
    #1;
    check("R1 after reset set2", 1'b0, 32'h0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule